// File: doc/BRIEF.md
# Chopped I/Q Sampling Sequencer

This block drives a receiver that measures the in-phase and quadrature components of a sinusoidal response using a single shared ADC. A multiplexer picks one of two reference clocks as the sampling clock. Two phase controls pick how the input reaches the converter: straight through (forward) or with the signal and common-mode legs exchanged (swapped). For each measurement the sequencer runs four conversions and stores the codes. It forms the forward-minus-swapped difference for I and for Q, which removes any offset or slow noise common to both polarities.

After a start pulse the block runs a window of 2^W measurements and sums the differences for each lane. When the window ends it publishes the floor-rounded averages as signed two's-complement values and pulses a done flag. The sequencer opens a sampling window by raising one phase control, and closes it when the converter reports a valid code. A guard cycle with both controls low comes before every window. Magnitude and phase extraction are left to downstream logic.

Top module: `chop_iq_sequencer`

## Requirements
- R1: `samp_clk` equals `ref_i_clk` while `samp_sel` is 0 and equals `ref_q_clk` while `samp_sel` is 1.
- R2: Each measurement consists of four conversions in this fixed order: (`samp_sel`=0, forward), (`samp_sel`=1, forward), (`samp_sel`=0, swapped), (`samp_sel`=1, swapped).
- R3: `chop_fwd` and `chop_swap` are never high together. In the cycle after a conversion's `adc_valid` is accepted, both are low.
- R4: `samp_sel`, `chop_fwd` and `chop_swap` hold their values for as long as a sampling window is open. A window lasts from the rise of a phase control until `adc_valid` is accepted.
- R5: The sequence advances only on `adc_valid` while a window is open. `adc_valid` while idle or in a guard cycle has no effect, and no window opens while `busy` is low.
- R6: `avg_i` equals floor(sum over the window of (I forward code − I swapped code) / 2^(W+1)) as a 12-bit two's-complement value, and `avg_q` is defined the same way for Q. A code offset or drift that is constant within one measurement cancels.
- R7: The window holds 2^W measurements, with W taken from `win_log2` at start; values above 12 act as 12. The block performs exactly 4·2^W conversions. `busy` falls after the last one, and then `done` is high for exactly one cycle, with the new averages present in that cycle.
- R8: An accepted start clears both accumulators so no earlier run leaks into the result. A start while `busy` is high is ignored.
- R9: A full 4096-measurement window with the extreme differences +4095 (I) and −4095 (Q) yields 2047 and −2048 without overflow.
- R10: After reset, `chop_fwd`, `chop_swap`, `busy`, `done`, `samp_sel`, `avg_i` and `avg_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i_clk | input | 1 | In-phase reference clock |
| ref_q_clk | input | 1 | Quadrature reference clock |
| start | input | 1 | Start pulse, taken only while idle |
| win_log2 | input | 4 | log2 of the window length in measurements (clamped to 12) |
| adc_valid | input | 1 | Converter result valid |
| adc_code | input | 12 | Unsigned converter code |
| samp_clk | output | 1 | Selected sampling clock |
| samp_sel | output | 1 | 0 selects in-phase, 1 selects quadrature |
| chop_fwd | output | 1 | Forward input connection active |
| chop_swap | output | 1 | Swapped input connection active |
| busy | output | 1 | Measurement window in progress |
| avg_i | output | 12 | Averaged I result, two's complement |
| avg_q | output | 12 | Averaged Q result, two's complement |
| done | output | 1 | One-cycle pulse when the averages are updated |

## Verification
Several properties are checked on every cycle:
- The two phase controls are mutually exclusive and drop right after a valid is accepted.
- The select and phase controls stay frozen while a window is open.
- No window opens while idle, and `done` never lasts two cycles.
- The averages change only in the `done` cycle.

Only the directed scenarios can show the rest: the conversion order, the exact floor-rounded averages with offset and drift present, window clamping and conversion counts, the full-scale 4096-measurement result, and the effect of stray valids and of a start while busy.

// File: rtl/chop_iq_pkg.sv
package chop_iq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GUARD  = 2'd1,
        ST_SAMPLE = 2'd2
    } seq_state_e;

    // Slot order inside one measurement: bit0 = lane (0 I, 1 Q), bit1 = swapped polarity
    localparam logic [1:0] SLOT_FINAL = 2'd3;

endpackage

// File: rtl/chop_iq_ctrl.sv
module chop_iq_ctrl
    import chop_iq_pkg::*;
#(
    parameter int unsigned WIN_LOG2_MAX = 12,
    parameter int unsigned WCFG_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WCFG_W-1:0] win_log2_i,
    input  logic              adc_valid_i,
    output logic              sel_o,
    output logic              chop_fwd_o,
    output logic              chop_swap_o,
    output logic              busy_o,
    output logic              cap_v_o,
    output logic [1:0]        cap_slot_o,
    output logic              cap_last_o,
    output logic              clr_o,
    output logic [WCFG_W-1:0] shift_o
);

    localparam int unsigned CNT_W = WIN_LOG2_MAX + 1;

    typedef struct packed {
        seq_state_e        st;
        logic [1:0]        slot;
        logic [CNT_W-1:0]  mcnt;
        logic [WCFG_W-1:0] wl;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic [CNT_W-1:0] lim;
    logic             last_meas;

    always_comb begin
        lim       = (CNT_W'(1) << r_q.wl) - CNT_W'(1);
        last_meas = (r_q.mcnt == lim);
        r_d       = r_q;
        clr_o     = 1'b0;
        cap_v_o   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    clr_o    = 1'b1;
                    r_d.st   = ST_GUARD;
                    r_d.slot = 2'd0;
                    r_d.mcnt = '0;
                    r_d.wl   = (win_log2_i > WCFG_W'(WIN_LOG2_MAX)) ?
                               WCFG_W'(WIN_LOG2_MAX) : win_log2_i;
                end
            end
            ST_GUARD: begin
                r_d.st = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (adc_valid_i) begin
                    cap_v_o  = 1'b1;
                    r_d.slot = r_q.slot + 2'd1;
                    r_d.st   = ST_GUARD;
                    if (r_q.slot == SLOT_FINAL) begin
                        r_d.mcnt = r_q.mcnt + CNT_W'(1);
                        if (last_meas) r_d.st = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, slot: 2'd0, mcnt: '0, wl: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_o       = r_q.slot[0];
    assign chop_fwd_o  = (r_q.st == ST_SAMPLE) && !r_q.slot[1];
    assign chop_swap_o = (r_q.st == ST_SAMPLE) &&  r_q.slot[1];
    assign busy_o      = (r_q.st != ST_IDLE);
    assign cap_slot_o  = r_q.slot;
    assign cap_last_o  = (r_q.slot == SLOT_FINAL) && last_meas;
    assign shift_o     = r_q.wl;

    assert_chop_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(chop_fwd_o && chop_swap_o));

    assert_chop_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_fwd_o || chop_swap_o) && adc_valid_i |=> !(chop_fwd_o || chop_swap_o));

    assert_hold_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_fwd_o || chop_swap_o) && !adc_valid_i |=>
            $stable(sel_o) && $stable(chop_fwd_o) && $stable(chop_swap_o));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(chop_fwd_o || chop_swap_o));

endmodule

// File: rtl/chop_iq_diff.sv
module chop_iq_diff #(
    parameter int unsigned ADC_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_v_i,
    input  logic [1:0]           cap_slot_i,
    input  logic                 cap_last_i,
    input  logic [ADC_W-1:0]     code_i,
    output logic                 pv_o,
    output logic                 plast_o,
    output logic [1:0][ADC_W:0]  d_o
);

    typedef struct packed {
        logic [1:0][ADC_W-1:0] pos;
        logic [1:0][ADC_W:0]   d;
        logic                  pv;
        logic                  plast;
    } diff_t;

    diff_t r_q, r_d;
    logic signed [ADC_W:0] delta;

    always_comb begin
        r_d      = r_q;
        r_d.pv   = 1'b0;
        r_d.plast = 1'b0;
        delta    = $signed({1'b0, r_q.pos[cap_slot_i[0]]}) - $signed({1'b0, code_i});
        if (cap_v_i) begin
            if (!cap_slot_i[1]) begin
                r_d.pos[cap_slot_i[0]] = code_i;
            end else begin
                r_d.d[cap_slot_i[0]] = delta;
                if (cap_slot_i[0]) begin
                    r_d.pv    = 1'b1;
                    r_d.plast = cap_last_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pv_o    = r_q.pv;
    assign plast_o = r_q.plast;
    assign d_o     = r_q.d;

endmodule

// File: rtl/chop_iq_accum.sv
module chop_iq_accum #(
    parameter int unsigned ADC_W        = 12,
    parameter int unsigned WIN_LOG2_MAX = 12,
    parameter int unsigned WCFG_W       = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  pv_i,
    input  logic                  plast_i,
    input  logic [WCFG_W-1:0]     shift_i,
    input  logic [1:0][ADC_W:0]   d_i,
    output logic [1:0][ADC_W-1:0] avg_o,
    output logic                  done_o
);

    localparam int unsigned ACC_W = ADC_W + 1 + WIN_LOG2_MAX;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [ADC_W-1:0]        avg;
    } lane_t;

    logic done_q, done_d;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        lane_t r_q, r_d;
        logic signed [ACC_W-1:0] add_v;
        logic signed [ACC_W-1:0] sum_v;

        always_comb begin
            add_v = ACC_W'($signed(d_i[g]));
            sum_v = r_q.acc + add_v;
            r_d   = r_q;
            if (pv_i) begin
                r_d.acc = sum_v;
                if (plast_i) begin
                    r_d.avg = ADC_W'(sum_v >>> ({1'b0, shift_i} + 1'b1));
                end
            end
            if (clr_i) r_d.acc = '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                r_q <= r_d;
            end
        end

        assign avg_o[g] = r_q.avg;
    end

    always_comb begin
        done_d = pv_i && plast_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_d;
        end
    end

    assign done_o = done_q;

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_avg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(avg_o));

endmodule

// File: rtl/chop_iq_sequencer.sv
module chop_iq_sequencer #(
    parameter int unsigned ADC_W        = 12,
    parameter int unsigned WIN_LOG2_MAX = 12
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  ref_i_clk,
    input  logic                                  ref_q_clk,
    input  logic                                  start,
    input  logic [$clog2(WIN_LOG2_MAX+1)-1:0]     win_log2,
    input  logic                                  adc_valid,
    input  logic [ADC_W-1:0]                      adc_code,
    output logic                                  samp_clk,
    output logic                                  samp_sel,
    output logic                                  chop_fwd,
    output logic                                  chop_swap,
    output logic                                  busy,
    output logic [ADC_W-1:0]                      avg_i,
    output logic [ADC_W-1:0]                      avg_q,
    output logic                                  done
);

    localparam int unsigned WCFG_W = $clog2(WIN_LOG2_MAX + 1);

    logic              cap_v, cap_last, clr, pv, plast;
    logic [1:0]        cap_slot;
    logic [WCFG_W-1:0] shift;
    logic [1:0][ADC_W:0]   d;
    logic [1:0][ADC_W-1:0] avg;

    chop_iq_ctrl #(
        .WIN_LOG2_MAX (WIN_LOG2_MAX),
        .WCFG_W       (WCFG_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .win_log2_i  (win_log2),
        .adc_valid_i (adc_valid),
        .sel_o       (samp_sel),
        .chop_fwd_o  (chop_fwd),
        .chop_swap_o (chop_swap),
        .busy_o      (busy),
        .cap_v_o     (cap_v),
        .cap_slot_o  (cap_slot),
        .cap_last_o  (cap_last),
        .clr_o       (clr),
        .shift_o     (shift)
    );

    chop_iq_diff #(
        .ADC_W (ADC_W)
    ) u_diff (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_v_i    (cap_v),
        .cap_slot_i (cap_slot),
        .cap_last_i (cap_last),
        .code_i     (adc_code),
        .pv_o       (pv),
        .plast_o    (plast),
        .d_o        (d)
    );

    chop_iq_accum #(
        .ADC_W        (ADC_W),
        .WIN_LOG2_MAX (WIN_LOG2_MAX),
        .WCFG_W       (WCFG_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .pv_i    (pv),
        .plast_i (plast),
        .shift_i (shift),
        .d_i     (d),
        .avg_o   (avg),
        .done_o  (done)
    );

    // Sampling-clock multiplexer: quadrature reference when samp_sel is high
    assign samp_clk = samp_sel ? ref_q_clk : ref_i_clk;
    assign avg_i    = avg[0];
    assign avg_q    = avg[1];

endmodule

// File: tb/test_chop_iq_sequencer.sv
module test_chop_iq_sequencer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_i_clk, ref_q_clk;
    logic        start;
    logic [3:0]  win_log2;
    logic        adc_valid;
    logic [11:0] adc_code;
    logic        samp_clk, samp_sel, chop_fwd, chop_swap, busy, done;
    logic [11:0] avg_i, avg_q;

    chop_iq_sequencer i_chop_iq_sequencer (
        .clk(clk), .rst_n(rst_n), .ref_i_clk(ref_i_clk), .ref_q_clk(ref_q_clk),
        .start(start), .win_log2(win_log2), .adc_valid(adc_valid), .adc_code(adc_code),
        .samp_clk(samp_clk), .samp_sel(samp_sel), .chop_fwd(chop_fwd), .chop_swap(chop_swap),
        .busy(busy), .avg_i(avg_i), .avg_q(avg_q), .done(done)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int mux_err = 0, gap_err = 0, hold_err = 0, dwid_err = 0, done_cnt = 0;
    int lat = 1, cnt = 0, conv_k = 0;
    int c_ia, c_ib, c_qa, c_qb, alt_i, alt_q, drift;
    logic m_v = 1'b0, stray_v = 1'b0, gave = 1'b0;
    logic [11:0] m_code = '0;
    logic [1:0] ord [4];
    logic [2:0] ph = '0;

    assign adc_valid = m_v | stray_v;
    assign adc_code  = m_v ? m_code : 12'hA5A;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] model_code();
        int m, v;
        bit odd;
        m   = conv_k >> 2;
        odd = (m % 2) == 1;
        if (!samp_sel) v = chop_fwd ? c_ia + (odd ? alt_i : 0) : c_ib;
        else           v = chop_fwd ? c_qa + (odd ? alt_q : 0) : c_qb;
        v = v + drift * m;
        return 12'(v);
    endfunction

    // Reference clocks, quarter period apart
    always @(negedge clk) begin
        ph        <= ph + 3'd1;
        ref_i_clk <= ph[2];
        ref_q_clk <= ph[2] ^ ph[1];
    end

    // Converter model: answers each open window after 'lat' cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            m_v = 1'b0; cnt = 0; gave = 1'b0;
        end else if (chop_fwd || chop_swap) begin
            if (!gave) begin
                if (cnt >= lat) begin
                    m_code = model_code();
                    m_v    = 1'b1;
                    if (conv_k < 4) ord[conv_k] = {samp_sel, chop_swap};
                    conv_k++;
                    gave = 1'b1;
                end else cnt++;
            end else m_v = 1'b0;
        end else begin
            m_v = 1'b0; gave = 1'b0; cnt = 0;
        end
    end

    // Port monitor
    logic p_act = 1'b0, p_sel = 1'b0, p_fwd = 1'b0, p_swp = 1'b0, p_mv = 1'b0, p_done = 1'b0;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (samp_clk !== (samp_sel ? ref_q_clk : ref_i_clk)) mux_err++;
            if (chop_fwd && chop_swap) gap_err++;
            if (p_act && p_mv && (chop_fwd || chop_swap)) gap_err++;
            if (p_act && !p_mv && (chop_fwd || chop_swap) &&
                (samp_sel != p_sel || chop_fwd != p_fwd || chop_swap != p_swp)) hold_err++;
            if (p_act && !p_mv && !(chop_fwd || chop_swap)) hold_err++;
            if (done) done_cnt++;
            if (done && p_done) dwid_err++;
        end
        p_act  = chop_fwd || chop_swap;
        p_sel  = samp_sel; p_fwd = chop_fwd; p_swp = chop_swap;
        p_mv   = m_v; p_done = done;
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            finish_run();
        end
    end

    task automatic set_codes(input int ia, input int ib, input int qa, input int qb,
                             input int ai, input int aq, input int dr);
        c_ia = ia; c_ib = ib; c_qa = qa; c_qb = qb; alt_i = ai; alt_q = aq; drift = dr;
    endtask

    task automatic run_meas(input string tag, input int wcfg, input bit poke_start);
        int weff, n, ei, eq, guard;
        weff = (wcfg > 12) ? 12 : wcfg;
        n    = 1 << weff;
        ei   = (n * (c_ia - c_ib) + (n >> 1) * alt_i) >>> (weff + 1);
        eq   = (n * (c_qa - c_qb) + (n >> 1) * alt_q) >>> (weff + 1);
        conv_k = 0; done_cnt = 0;
        @(negedge clk); start = 1'b1; win_log2 = 4'(wcfg);
        @(negedge clk); start = 1'b0; win_log2 = 4'd0;
        guard = 0;
        while (!done && guard < 150000) begin
            @(negedge clk); #3; guard++;
            if (poke_start && guard == 20) begin start = 1'b1; win_log2 = 4'd0; end
            if (poke_start && guard == 21) start = 1'b0;
        end
        chk(done == 1'b1, {"R7 done seen ", tag}, int'(done), 1);
        chk(int'($signed(avg_i)) == ei, {"R6 avg_i ", tag}, int'($signed(avg_i)), ei);
        chk(int'($signed(avg_q)) == eq, {"R6 avg_q ", tag}, int'($signed(avg_q)), eq);
        repeat (3) @(negedge clk);
        #3;
        chk(done_cnt == 1, {"R7 single done ", tag}, done_cnt, 1);
        chk(conv_k == 4 * n, {"R7 conversion count ", tag}, conv_k, 4 * n);
        chk(!busy, {"R7 busy cleared ", tag}, int'(busy), 0);
        chk(mux_err == 0, {"R1 clock mux ", tag}, mux_err, 0);
        chk(gap_err == 0, {"R3 phase gap ", tag}, gap_err, 0);
        chk(hold_err == 0, {"R4 window hold ", tag}, hold_err, 0);
        chk(dwid_err == 0, {"R7 done width ", tag}, dwid_err, 0);
    endtask

    task automatic t_reset();
        #3;
        chk(!chop_fwd && !chop_swap, "R10 phases low", int'({chop_fwd, chop_swap}), 0);
        chk(!busy && !done, "R10 busy/done low", int'({busy, done}), 0);
        chk(!samp_sel, "R10 select low", int'(samp_sel), 0);
        chk(avg_i == 12'd0 && avg_q == 12'd0, "R10 averages zero", int'(avg_i) + int'(avg_q), 0);
    endtask

    task automatic t_basic();
        lat = 1;
        set_codes(2148, 1948, 1998, 2098, 0, 0, 0);
        run_meas("basic", 2, 1'b0);
        chk(ord[0] == 2'b00, "R2 slot0 I fwd", int'(ord[0]), 0);
        chk(ord[1] == 2'b10, "R2 slot1 Q fwd", int'(ord[1]), 2);
        chk(ord[2] == 2'b01, "R2 slot2 I swap", int'(ord[2]), 1);
        chk(ord[3] == 2'b11, "R2 slot3 Q swap", int'(ord[3]), 3);
    endtask

    task automatic t_offset_drift();
        lat = 3;
        set_codes(2048 + 37 + 300, 2048 + 37 - 300, 2048 + 37 - 125, 2048 + 37 + 125, 0, 0, 5);
        run_meas("R6 offset drift", 3, 1'b0);
    endtask

    task automatic t_rounding();
        lat = 0;
        set_codes(2051, 2045, 2045, 2051, 1, -1, 0);
        run_meas("R6 floor rounding", 1, 1'b0);
        set_codes(2050, 2047, 2047, 2052, 0, 0, 0);
        run_meas("R6 single measurement", 0, 1'b0);
    endtask

    task automatic t_stray();
        lat = 2;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); stray_v = 1'b1;
            #3;
            chk(!busy && !chop_fwd && !chop_swap, "R5 stray valid while idle",
                int'({busy, chop_fwd, chop_swap}), 0);
        end
        @(negedge clk); stray_v = 1'b0;
        set_codes(2100, 2000, 2000, 2100, 0, 0, 0);
        run_meas("R5 after stray", 2, 1'b0);
    endtask

    task automatic t_busy_start();
        lat = 1;
        set_codes(1000, 3000, 3500, 500, 0, 0, 0);
        run_meas("R8 start while busy", 2, 1'b1);
        set_codes(2060, 2040, 2030, 2070, 0, 0, 0);
        run_meas("R8 accumulators cleared", 2, 1'b0);
    endtask

    task automatic t_full_window();
        lat = 0;
        set_codes(4095, 0, 0, 4095, 0, 0, 0);
        run_meas("R9 full scale clamp", 15, 1'b0);
        chk(int'($signed(avg_i)) == 2047, "R9 positive extreme", int'($signed(avg_i)), 2047);
        chk(int'($signed(avg_q)) == -2048, "R9 negative extreme", int'($signed(avg_q)), -2048);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; win_log2 = 4'd0;
        ref_i_clk = 1'b0; ref_q_clk = 1'b0;
        set_codes(2048, 2048, 2048, 2048, 0, 0, 0);
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic();
        t_offset_drift();
        t_rounding();
        t_stray();
        t_busy_start();
        t_full_window();
        finish_run();
    end

endmodule